// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of level-sensitive interrupt request lines and a processor core. Each maskable line has an enable bit and two priority fields, a preemption field and a sub field, written through a one-line-per-cycle configuration port. From the requests that are asserted, enabled and not already being serviced, the block picks a winner. It then announces the winner to the core with a one-cycle entry strobe and the line number.

The block keeps a stack of the handlers that are currently running. A waiting request enters only when the stack is empty or when its preemption field is strictly more urgent than the handler on top. When the core pulses the return input, the top handler is removed and the interrupted level becomes the reference again. A separate non-maskable input outranks every maskable line, has no enable, and cannot be preempted.

Priority fields are 2 bits each. A numerically lower value is more urgent. The line number reported is the request's bit index.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset no strobe is issued, no handler is running, `run_pre_o` is 0, and every line is disabled with both priority fields 0.
- R2: A line whose enable bit (written through `cfg_en_i` for line `cfg_sel_i` while `cfg_we_i` is high) is 0 is never accepted, even while it is requesting.
- R3: Among waiting candidates, the one with the numerically lowest preemption field wins.
- R4: When the preemption fields tie, the lowest sub field wins.
- R5: When both fields tie, the lowest line number wins.
- R6: While a handler runs, a maskable request is accepted only if its preemption field is strictly lower than the running level. An equal or higher field waits, whatever its sub field is.
- R7: A return pulse on `done_i` removes the top handler, and the handler below it becomes the running level on `run_pre_o`.
- R8: The non-maskable request is accepted over any maskable candidate and preempts any maskable handler (`take_nmi_o`=1, `run_nmi_o`=1). While it runs, no maskable line is accepted.
- R9: An accepted line is not accepted again until its handler returns. If it is still requesting after the return, it becomes a candidate again.
- R10: `take_o` is high for exactly one cycle, in the cycle after the edge at which the request was seen. In a cycle with `done_i` high, no request is accepted; the decision is made one cycle later against the restored level.
- R11: A return pulse while no handler runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | NUM_LINES | Level-sensitive maskable requests |
| nmi_req_i | input | 1 | Non-maskable request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | ID_W | Line written |
| cfg_en_i | input | 1 | Enable bit value |
| cfg_pre_i | input | PRE_W | Preemption field value |
| cfg_sub_i | input | SUB_W | Sub field value |
| done_i | input | 1 | Handler return pulse |
| take_o | output | 1 | Entry strobe |
| take_nmi_o | output | 1 | Strobe is for the non-maskable request |
| take_id_o | output | ID_W | Line number accepted |
| run_valid_o | output | 1 | A handler is running |
| run_nmi_o | output | 1 | Running handler is the non-maskable one |
| run_pre_o | output | PRE_W | Preemption field of the running maskable handler |

## Verification
Two functions can meet in one cycle: a handler return and the acceptance of a new request. The bench holds a request waiting (one with an equal field, or a more urgent one behind the non-maskable handler) while it pulses `done_i`. It then checks that no strobe follows the return cycle, and that the strobe arrives one cycle later with the line the restored level allows. A second collision is the non-maskable request and a more urgent maskable line arriving on the same edge. A swept phase checks simultaneous multi-line requests against a winner computed in the bench.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int DEF_LINES = 32;
  localparam int DEF_PRE_W = 2;
  localparam int DEF_SUB_W = 2;
  localparam int DEF_DEPTH = 8;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N     = nirq_pkg::DEF_LINES,
  parameter int PRE_W = nirq_pkg::DEF_PRE_W,
  parameter int SUB_W = nirq_pkg::DEF_SUB_W,
  parameter int ID_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ID_W-1:0]           sel_i,
  input  logic                      en_i,
  input  logic [PRE_W-1:0]          pre_i,
  input  logic [SUB_W-1:0]          sub_i,
  output logic [N-1:0]              en_o,
  output logic [N-1:0][PRE_W-1:0]   pre_o,
  output logic [N-1:0][SUB_W-1:0]   sub_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic wr_en;
    assign wr_en = we_i && (sel_i == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_o[g]  <= 1'b0;
        pre_o[g] <= '0;
        sub_o[g] <= '0;
      end else if (wr_en) begin
        en_o[g]  <= en_i;
        pre_o[g] <= pre_i;
        sub_o[g] <= sub_i;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N     = nirq_pkg::DEF_LINES,
  parameter int PRE_W = nirq_pkg::DEF_PRE_W,
  parameter int SUB_W = nirq_pkg::DEF_SUB_W,
  parameter int ID_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             cand_i,
  input  logic [N-1:0][PRE_W-1:0]  pre_i,
  input  logic [N-1:0][SUB_W-1:0]  sub_i,
  output logic                     win_vld_o,
  output logic [ID_W-1:0]          win_id_o,
  output logic [PRE_W-1:0]         win_pre_o
);
  localparam int KW = PRE_W + SUB_W;
  logic [KW-1:0] best_key;

  // Ascending scan with strict compare: on a full tie the lowest index stays.
  always_comb begin
    win_vld_o = 1'b0;
    win_id_o  = '0;
    best_key  = '1;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!win_vld_o || {pre_i[i], sub_i[i]} < best_key)) begin
        win_vld_o = 1'b1;
        win_id_o  = ID_W'(i);
        best_key  = {pre_i[i], sub_i[i]};
      end
    end
    win_pre_o = best_key[KW-1 -: PRE_W];
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int DEPTH = nirq_pkg::DEF_DEPTH,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [W-1:0]  mem_q [DEPTH];
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign top_o   = mem_q[AW'(cnt_q - CW'(1))];

  always_comb begin
    cnt_nxt = cnt_q;
    if (do_push)     cnt_nxt = cnt_q + CW'(1);
    else if (do_pop) cnt_nxt = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[AW'(cnt_q)] <= data_i;
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int NUM_LINES = nirq_pkg::DEF_LINES,
  parameter int PRE_W     = nirq_pkg::DEF_PRE_W,
  parameter int SUB_W     = nirq_pkg::DEF_SUB_W,
  parameter int DEPTH     = nirq_pkg::DEF_DEPTH,
  localparam int ID_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req_i,
  input  logic                 nmi_req_i,
  input  logic                 cfg_we_i,
  input  logic [ID_W-1:0]      cfg_sel_i,
  input  logic                 cfg_en_i,
  input  logic [PRE_W-1:0]     cfg_pre_i,
  input  logic [SUB_W-1:0]     cfg_sub_i,
  input  logic                 done_i,
  output logic                 take_o,
  output logic                 take_nmi_o,
  output logic [ID_W-1:0]      take_id_o,
  output logic                 run_valid_o,
  output logic                 run_nmi_o,
  output logic [PRE_W-1:0]     run_pre_o
);
  localparam int EW = 1 + PRE_W + ID_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_LINES-1:0]            en_vec;
  logic [NUM_LINES-1:0][PRE_W-1:0] pre_tab;
  logic [NUM_LINES-1:0][SUB_W-1:0] sub_tab;

  irq_cfg_regs #(.N(NUM_LINES), .PRE_W(PRE_W), .SUB_W(SUB_W), .ID_W(ID_W)) cfg_i (
    .clk(clk), .rst_n(rst_int_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .en_i(cfg_en_i), .pre_i(cfg_pre_i), .sub_i(cfg_sub_i),
    .en_o(en_vec), .pre_o(pre_tab), .sub_o(sub_tab));

  logic [NUM_LINES-1:0] in_svc_q, in_svc_nxt, cand;
  logic                 nmi_svc_q, nmi_svc_nxt, nmi_pend;
  logic                 win_vld;
  logic [ID_W-1:0]      win_id;
  logic [PRE_W-1:0]     win_pre;

  assign cand     = irq_req_i & en_vec & ~in_svc_q;
  assign nmi_pend = nmi_req_i && !nmi_svc_q;

  irq_arbiter #(.N(NUM_LINES), .PRE_W(PRE_W), .SUB_W(SUB_W), .ID_W(ID_W)) arb_i (
    .cand_i(cand), .pre_i(pre_tab), .sub_i(sub_tab),
    .win_vld_o(win_vld), .win_id_o(win_id), .win_pre_o(win_pre));

  logic [EW-1:0]    top_w, push_w;
  logic             stk_empty, stk_full, top_nmi;
  logic [PRE_W-1:0] top_pre;
  logic [ID_W-1:0]  top_id;
  logic             acc_nmi, acc_irq, push, pop;

  assign top_nmi = top_w[EW-1];
  assign top_pre = top_w[ID_W +: PRE_W];
  assign top_id  = top_w[ID_W-1:0];

  // a return cycle never accepts; arbitration resumes against the restored level
  assign acc_nmi = nmi_pend && !done_i && !stk_full && (stk_empty || !top_nmi);
  assign acc_irq = !nmi_pend && win_vld && !done_i && !stk_full &&
                   (stk_empty || (!top_nmi && (win_pre < top_pre)));
  assign push    = acc_nmi || acc_irq;
  assign pop     = done_i && !stk_empty;
  assign push_w  = acc_nmi ? {1'b1, {(PRE_W + ID_W){1'b0}}} : {1'b0, win_pre, win_id};

  irq_level_stack #(.DEPTH(DEPTH), .W(EW)) stk_i (
    .clk(clk), .rst_n(rst_int_n), .push_i(push), .pop_i(pop), .data_i(push_w),
    .top_o(top_w), .empty_o(stk_empty), .full_o(stk_full));

  always_comb begin
    in_svc_nxt  = in_svc_q;
    nmi_svc_nxt = nmi_svc_q;
    if (pop) begin
      if (top_nmi) nmi_svc_nxt = 1'b0;
      else         in_svc_nxt[top_id] = 1'b0;
    end
    if (acc_irq) in_svc_nxt[win_id] = 1'b1;
    if (acc_nmi) nmi_svc_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      in_svc_q   <= '0;
      nmi_svc_q  <= 1'b0;
      take_o     <= 1'b0;
      take_nmi_o <= 1'b0;
      take_id_o  <= '0;
    end else begin
      in_svc_q   <= in_svc_nxt;
      nmi_svc_q  <= nmi_svc_nxt;
      take_o     <= push;
      take_nmi_o <= acc_nmi;
      if (push) take_id_o <= acc_nmi ? '0 : win_id;
    end
  end

  assign run_valid_o = !stk_empty;
  assign run_nmi_o   = !stk_empty && top_nmi;
  assign run_pre_o   = (stk_empty || top_nmi) ? '0 : top_pre;
endmodule

// File: rtl/nested_irq_ctrl_chk.sv
module nested_irq_ctrl_chk #(
  parameter int N     = 32,
  parameter int PRE_W = 2,
  parameter int ID_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     irq_req_i,
  input logic [N-1:0]     en_vec,
  input logic             done_i,
  input logic             take_o,
  input logic             take_nmi_o,
  input logic [ID_W-1:0]  take_id_o,
  input logic             run_valid_o,
  input logic             run_nmi_o,
  input logic [PRE_W-1:0] run_pre_o
);
  logic [N-1:0]     elig_q;
  logic             prev_valid_q, prev_nmi_q, done_q;
  logic [PRE_W-1:0] prev_pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q       <= '0;
      prev_valid_q <= 1'b0;
      prev_nmi_q   <= 1'b0;
      prev_pre_q   <= '0;
      done_q       <= 1'b0;
    end else begin
      elig_q       <= irq_req_i & en_vec;
      prev_valid_q <= run_valid_o;
      prev_nmi_q   <= run_nmi_o;
      prev_pre_q   <= run_pre_o;
      done_q       <= done_i;
    end
  end

  // R2
  take_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && !take_nmi_o |-> elig_q[take_id_o]);

  // R6
  strict_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && !take_nmi_o && prev_valid_q |-> !prev_nmi_q && (run_pre_o < prev_pre_q));

  // R8
  nmi_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> take_o && run_nmi_o);

  // R10
  no_take_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !take_o);

  // R10
  take_pushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> run_valid_o);

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !run_valid_o |=> !run_valid_o);
endmodule

bind nested_irq_ctrl nested_irq_ctrl_chk #(.N(NUM_LINES), .PRE_W(PRE_W), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .en_vec(en_vec), .done_i(done_i),
  .take_o(take_o), .take_nmi_o(take_nmi_o), .take_id_o(take_id_o),
  .run_valid_o(run_valid_o), .run_nmi_o(run_nmi_o), .run_pre_o(run_pre_o));

// File: tb/nested_irq_ctrl_tb_top.sv
module nested_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq;
  logic        nmi, cfg_we, cfg_en, done;
  logic [4:0]  cfg_sel;
  logic [1:0]  cfg_pre, cfg_sub;
  logic        take, take_nmi, run_valid, run_nmi;
  logic [4:0]  take_id;
  logic [1:0]  run_pre;
  int          nchk = 0, nerr = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  nested_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .nmi_req_i(nmi),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_en_i(cfg_en),
    .cfg_pre_i(cfg_pre), .cfg_sub_i(cfg_sub), .done_i(done),
    .take_o(take), .take_nmi_o(take_nmi), .take_id_o(take_id),
    .run_valid_o(run_valid), .run_nmi_o(run_nmi), .run_pre_o(run_pre));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(int line, bit e, int p, int s);
    cfg_we = 1'b1; cfg_sel = 5'(line); cfg_en = e; cfg_pre = 2'(p); cfg_sub = 2'(s);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic ret();
    done = 1'b1;
    tick();
    done = 1'b0;
  endtask

  task automatic expect_take(int id, string tag);
    chk(take === 1'b1, {tag, " strobe"}, int'(take), 1);
    chk(take_id == 5'(id) && !take_nmi, {tag, " id"}, int'(take_id), id);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; irq = '0; nmi = 1'b0; cfg_we = 1'b0; cfg_en = 1'b0;
    cfg_sel = '0; cfg_pre = '0; cfg_sub = '0; done = 1'b0;
    repeat (4) tick();
    chk(!take && !run_valid && run_pre == 0, "R1 in reset", int'(run_valid), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    // R1: lines start disabled
    irq = 32'h0000_00FF;
    repeat (3) tick();
    chk(!take && !run_valid && run_pre == 0, "R1 after reset", int'(take), 0);
    irq = '0;
    tick();

    // sweep of simultaneous requests: R3 R4 R5
    for (int t = 0; t < 80; t++) begin
      int en[32], pr[32], sb[32];
      int best;
      string tag;
      for (int i = 0; i < 32; i++) begin
        en[i] = (((i + t) % 5) != 0) ? 1 : 0;
        pr[i] = (i * 7 + t) % 4;
        sb[i] = (i * 3 + t * 5) % 4;
        cfg(i, en[i] != 0, pr[i], sb[i]);
      end
      best = -1;
      tag = "R3";
      for (int i = 0; i < 32; i++) begin
        if (((i * 11 + t * 13) % 7) < 3) begin
          irq[i] = 1'b1;
          if (en[i] != 0) begin
            if (best < 0) best = i;
            else if (pr[i] < pr[best] || (pr[i] == pr[best] && sb[i] < sb[best])) best = i;
          end
        end
      end
      if (best >= 0) begin
        tag = "R3";
        for (int i = 0; i < 32; i++) begin
          if (irq[i] && en[i] != 0 && i != best && pr[i] == pr[best]) begin
            if (sb[i] == sb[best]) tag = "R5";
            else if (tag == "R3") tag = "R4";
          end
        end
      end
      tick();
      if (best >= 0) begin
        expect_take(best, tag);
        tick();
        chk(!take, "R10 single strobe", int'(take), 0);
        irq = '0;
        ret();
        tick();
      end else begin
        chk(!take, "R2 none enabled", int'(take), 0);
        irq = '0;
        tick();
      end
    end

    for (int i = 0; i < 32; i++) cfg(i, 1'b0, 0, 0);

    // R2: disabled line with the most urgent fields
    cfg(4, 1'b0, 0, 0);
    irq[4] = 1'b1;
    repeat (3) begin tick(); chk(!take, "R2 disabled line", int'(take), 0); end
    irq[4] = 1'b0;

    cfg(3, 1'b1, 2, 3);
    cfg(5, 1'b1, 2, 0);
    cfg(7, 1'b1, 1, 3);
    cfg(9, 1'b1, 0, 0);
    irq[3] = 1'b1;
    tick();
    expect_take(3, "R10 first entry");
    tick();
    chk(!take && run_pre == 2, "R10 strobe one cycle", int'(take), 0);
    irq[5] = 1'b1;
    tick(); tick();
    chk(!take, "R6 equal preemption waits", int'(take), 0);
    chk(!take, "R9 no retake while in service", int'(take), 0);
    irq[7] = 1'b1;
    tick();
    expect_take(7, "R6 preempt");
    chk(run_pre == 1, "R6 level", int'(run_pre), 1);
    nmi = 1'b1; irq[9] = 1'b1;
    tick();
    chk(take && take_nmi && run_nmi, "R8 nmi wins", int'(take_nmi), 1);
    tick(); tick();
    chk(!take && run_nmi, "R8 nmi not preempted", int'(take), 0);
    nmi = 1'b0;
    ret();
    chk(!take, "R10 no accept in return cycle", int'(take), 0);
    chk(!run_nmi && run_pre == 1, "R7 restored after nmi", int'(run_pre), 1);
    tick();
    expect_take(9, "R7 decision on restored level");
    irq[9] = 1'b0;
    ret();
    chk(run_pre == 1 && run_valid, "R7 back to line 7", int'(run_pre), 1);
    irq[7] = 1'b0;
    ret();
    chk(run_pre == 2, "R7 back to line 3", int'(run_pre), 2);
    tick();
    chk(!take, "R6 sub field cannot preempt", int'(take), 0);
    ret();
    chk(!take && !run_valid, "R10 return blocks accept", int'(take), 0);
    tick();
    expect_take(5, "R4 sub field orders waiting");
    irq[5] = 1'b0;
    ret();
    tick();
    expect_take(3, "R9 repend after return");
    irq[3] = 1'b0;
    ret();
    tick();
    chk(!run_valid, "R7 all returned", int'(run_valid), 0);
    ret();
    chk(!run_valid && !take, "R11 idle return", int'(run_valid), 0);
    tick();
    chk(!take && run_pre == 0, "R11 idle state", int'(take), 0);
    summary();
  end
endmodule